// File: doc/BRIEF.md
# Posted Write Buffer Retry Controller

This block sits between the slave side of a processor bus and the request port of a memory controller. It holds one posted processor-to-memory write, up to a full 32-byte cache line, and answers every processor address tenure with either an acknowledge or a retry. The answer depends on the transfer direction, whether the buffer is occupied, and whether the tenure's line matches the buffered line.

Conflicting accesses are never merged or forwarded. A read to the buffered line, or any write while the buffer is occupied, is retried, and the pending buffer drain is marked high priority so that it wins the request port. Accepted reads and buffer drains are turned into memory controller requests. A single-beat transfer becomes one doubleword with byte enables. A burst becomes four doublewords that wrap inside the line, starting at the critical doubleword. A request's address may be handed over while an earlier data phase is still running. Its data phase is started only after that earlier phase reports completion.

Top module: `pwb_retry_ctrl`

## Requirements
- R1: A read tenure while the buffer is empty and no earlier read is waiting is acknowledged, and a read request (`mc_req_wr`=0) for its address follows.
- R2: A read tenure whose line differs from the occupied buffer's line bypasses the buffer: it is acknowledged and produces its own read request.
- R3: A read tenure whose line (address bits above bit 4) equals the occupied buffer's line is retried. If the drain has not yet been handed over, that drain is presented with `mc_req_hipri`=1.
- R4: A write tenure while the buffer is empty is acknowledged and posted. The buffer later drains as a write request carrying the tenure's address.
- R5: A write tenure while the buffer is occupied, whether or not its line matches, is retried, and the drain is raised to high priority as in R3.
- R6: A single-beat transfer yields a request with `mc_req_burst`=0, the doubleword address (address bits above bit 2), and the tenure's byte enables.
- R7: A burst transfer yields a request with `mc_req_burst`=1, all byte enables set, and `mc_req_order` field i (bits 2i+1:2i) equal to (start doubleword index + i) mod 4.
- R8: Exactly one of `pb_aack_n` and `pb_artry_n` is low, for one cycle, in the cycle after each tenure. Both are high in every other cycle, including after reset.
- R9: When a new request is chosen and the buffer holds a drain not yet handed over, the drain is chosen ahead of any waiting read.
- R10: A request is presented only when no accepted address is waiting for its data phase. `mc_data_go` pulses for a waiting address only once no data phase is running, that is, only after `mc_data_done` ends the previous phase.
- R11: The buffer stays occupied until `mc_data_done` ends the drain's data phase. A write tenure in the cycle after that is posted.
- R12: A read tenure that misses the buffer while an earlier acknowledged read has not yet been handed over is retried, and the buffer's priority is left unchanged.
- R13: While `mc_req` is high and `mc_req_rdy` is low, the request's direction, address, burst flag, byte enables and order are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_ts | input | 1 | Address tenure start strobe |
| pb_addr | input | ADDR_W | Tenure byte address |
| pb_wr | input | 1 | 1 = write, 0 = read |
| pb_burst | input | 1 | 1 = 32-byte burst, 0 = single beat |
| pb_be | input | DW_BYTES | Byte enables of a single beat |
| pb_aack_n | output | 1 | Address acknowledge, active low |
| pb_artry_n | output | 1 | Address retry, active low |
| mc_req | output | 1 | Memory request valid |
| mc_req_rdy | input | 1 | Memory controller takes the address |
| mc_req_wr | output | 1 | Request is a buffer drain write |
| mc_req_hipri | output | 1 | High-priority drain |
| mc_req_burst | output | 1 | Four-doubleword wrapping burst |
| mc_req_addr | output | ADDR_W-3 | Start doubleword address |
| mc_req_be | output | DW_BYTES | Byte enables |
| mc_req_order | output | 2*BEATS | Doubleword index per beat |
| mc_data_go | output | 1 | Start data phase of the waiting address |
| mc_data_done | input | 1 | Running data phase has completed |

## Verification
The bench builds the block with ADDR_W=12 and the default doubleword and beat counts. Its stimulus draws tenure addresses from only four lines, so read hits, write conflicts and read bypasses all occur often. The narrow request address keeps the full wrap order and every doubleword start index within reach. Phases with a stalling request port and slow data completion keep the buffer occupied and the read slot full, which brings out R5, R9, R12 and R13.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {RSP_NONE = 2'd0, RSP_ACK = 2'd1, RSP_RETRY = 2'd2} rsp_e;
  typedef struct packed {
    rsp_e rsp;
    logic post;
    logic force_fl;
    logic rd_take;
  } dec_t;
endpackage

// File: rtl/pwb_decide.sv
module pwb_decide
  import pwb_pkg::*;
#(
  parameter int LINE_W = 27
) (
  input  logic              ts,
  input  logic              wr,
  input  logic [LINE_W-1:0] line,
  input  logic              buf_valid,
  input  logic [LINE_W-1:0] buf_line,
  input  logic              rd_busy,
  output dec_t              dec
);
  logic hit;

  always_comb begin
    hit          = buf_valid && (line == buf_line);
    dec.rsp      = RSP_NONE;
    dec.post     = 1'b0;
    dec.force_fl = 1'b0;
    dec.rd_take  = 1'b0;
    if (ts) begin
      if (wr) begin
        if (buf_valid) begin
          dec.rsp      = RSP_RETRY;
          dec.force_fl = 1'b1;
        end else begin
          dec.rsp  = RSP_ACK;
          dec.post = 1'b1;
        end
      end else if (hit) begin
        dec.rsp      = RSP_RETRY;
        dec.force_fl = 1'b1;
      end else if (rd_busy) begin
        dec.rsp = RSP_RETRY;
      end else begin
        dec.rsp     = RSP_ACK;
        dec.rd_take = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwb_buf.sv
module pwb_buf #(
  parameter int LINE_W = 27,
  parameter int IDX_W  = 2,
  parameter int BE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post,
  input  logic              force_fl,
  input  logic [LINE_W-1:0] in_line,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [BE_W-1:0]   in_be,
  input  logic              in_burst,
  input  logic              flush_issue,
  input  logic              flush_done,
  output logic              valid,
  output logic              issued,
  output logic              hipri,
  output logic [LINE_W-1:0] line,
  output logic [IDX_W-1:0]  idx,
  output logic [BE_W-1:0]   be,
  output logic              burst
);
  logic valid_n, issued_n, hipri_n;

  always_comb begin
    valid_n  = valid;
    issued_n = issued;
    hipri_n  = hipri;
    if (post) valid_n = 1'b1;
    if (flush_issue) begin
      issued_n = 1'b1;
      hipri_n  = 1'b0;
    end else if (force_fl && valid && !issued) begin
      hipri_n = 1'b1;
    end
    if (flush_done) begin
      valid_n  = 1'b0;
      issued_n = 1'b0;
      hipri_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      issued <= 1'b0;
      hipri  <= 1'b0;
    end else begin
      valid  <= valid_n;
      issued <= issued_n;
      hipri  <= hipri_n;
    end
  end

  always_ff @(posedge clk) begin
    if (post) begin
      line  <= in_line;
      idx   <= in_idx;
      be    <= in_be;
      burst <= in_burst;
    end
  end

  // R4
  post_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) post |-> !valid);
  // R11
  done_of_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (valid && issued));
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq #(
  parameter int LINE_W = 27,
  parameter int IDX_W  = 2,
  parameter int BE_W   = 8,
  parameter int BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_take,
  input  logic [LINE_W-1:0]       in_line,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic [BE_W-1:0]         in_be,
  input  logic                    in_burst,
  input  logic                    buf_valid,
  input  logic                    buf_issued,
  input  logic                    buf_hipri,
  input  logic [LINE_W-1:0]       buf_line,
  input  logic [IDX_W-1:0]        buf_idx,
  input  logic [BE_W-1:0]         buf_be,
  input  logic                    buf_burst,
  output logic                    rd_valid,
  output logic                    flush_issue,
  output logic                    flush_done,
  output logic                    req,
  input  logic                    req_rdy,
  output logic                    req_wr,
  output logic                    req_hipri,
  output logic                    req_burst,
  output logic [LINE_W+IDX_W-1:0] req_addr,
  output logic [BE_W-1:0]         req_be,
  output logic [BEATS*IDX_W-1:0]  req_order,
  output logic                    data_go,
  input  logic                    data_done
);
  logic              lock_q, lock_fl_q, pend_q, pend_fl_q, busy_q, cur_fl_q;
  logic              lock_n, lock_fl_n, pend_n, pend_fl_n, busy_n, cur_fl_n;
  logic              rd_valid_n, sel_flush, accept;
  logic [LINE_W-1:0] rd_line;
  logic [IDX_W-1:0]  rd_idx, s_idx;
  logic [BE_W-1:0]   rd_be;
  logic              rd_burst;

  always_comb begin
    sel_flush   = lock_q ? lock_fl_q : (buf_valid && !buf_issued);
    req         = !pend_q && (sel_flush || rd_valid);
    accept      = req && req_rdy;
    flush_issue = accept && sel_flush;
    data_go     = pend_q && !busy_q;
    flush_done  = data_done && busy_q && cur_fl_q;
    req_wr      = sel_flush;
    req_hipri   = sel_flush && buf_hipri;
    req_burst   = sel_flush ? buf_burst : rd_burst;
    s_idx       = sel_flush ? buf_idx : rd_idx;
    req_addr    = {sel_flush ? buf_line : rd_line, s_idx};
    req_be      = req_burst ? {BE_W{1'b1}} : (sel_flush ? buf_be : rd_be);

    lock_n     = req && !req_rdy;
    lock_fl_n  = sel_flush;
    pend_n     = accept ? 1'b1 : (data_go ? 1'b0 : pend_q);
    pend_fl_n  = accept ? sel_flush : pend_fl_q;
    busy_n     = data_go ? 1'b1 : (data_done ? 1'b0 : busy_q);
    cur_fl_n   = data_go ? pend_fl_q : cur_fl_q;
    rd_valid_n = rd_take ? 1'b1 : ((accept && !sel_flush) ? 1'b0 : rd_valid);
  end

  for (genvar i = 0; i < BEATS; i++) begin : g_order
    assign req_order[i*IDX_W +: IDX_W] = req_burst ? s_idx + IDX_W'(i) : s_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      lock_fl_q <= 1'b0;
      pend_q    <= 1'b0;
      pend_fl_q <= 1'b0;
      busy_q    <= 1'b0;
      cur_fl_q  <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      lock_q    <= lock_n;
      lock_fl_q <= lock_fl_n;
      pend_q    <= pend_n;
      pend_fl_q <= pend_fl_n;
      busy_q    <= busy_n;
      cur_fl_q  <= cur_fl_n;
      rd_valid  <= rd_valid_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_take) begin
      rd_line  <= in_line;
      rd_idx   <= in_idx;
      rd_be    <= in_be;
      rd_burst <= in_burst;
    end
  end

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_rdy) |=> (req && $stable(req_addr) && $stable(req_wr) && $stable(req_be)
                           && $stable(req_burst) && $stable(req_order)));
  // R10
  go_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go) |=> !data_go);
  // R10
  no_req_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_rdy) |=> !req);
  // R12
  one_read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |-> !rd_valid);
endmodule

// File: rtl/pwb_retry_ctrl.sv
module pwb_retry_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DW_BYTES = 8,
  parameter int BEATS    = 4,
  localparam int DW_OFS  = $clog2(DW_BYTES),
  localparam int IDX_W   = $clog2(BEATS),
  localparam int OFS_W   = DW_OFS + IDX_W,
  localparam int LINE_W  = ADDR_W - OFS_W,
  localparam int MA_W    = ADDR_W - DW_OFS,
  localparam int ORD_W   = BEATS * IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pb_ts,
  input  logic [ADDR_W-1:0]   pb_addr,
  input  logic                pb_wr,
  input  logic                pb_burst,
  input  logic [DW_BYTES-1:0] pb_be,
  output logic                pb_aack_n,
  output logic                pb_artry_n,
  output logic                mc_req,
  input  logic                mc_req_rdy,
  output logic                mc_req_wr,
  output logic                mc_req_hipri,
  output logic                mc_req_burst,
  output logic [MA_W-1:0]     mc_req_addr,
  output logic [DW_BYTES-1:0] mc_req_be,
  output logic [ORD_W-1:0]    mc_req_order,
  output logic                mc_data_go,
  input  logic                mc_data_done
);
  logic [1:0]        rst_sync;
  logic              arst_n;
  dec_t              dec;
  logic [LINE_W-1:0] t_line, b_line;
  logic [IDX_W-1:0]  t_idx, b_idx;
  logic [DW_BYTES-1:0] b_be;
  logic              b_valid, b_issued, b_hipri, b_burst;
  logic              rd_valid, flush_issue, flush_done;
  logic              aack_n_nx, artry_n_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign arst_n = rst_sync[1];

  assign t_line = pb_addr[ADDR_W-1:OFS_W];
  assign t_idx  = pb_addr[OFS_W-1:DW_OFS];

  pwb_decide #(.LINE_W(LINE_W)) u_decide (
    .ts(pb_ts), .wr(pb_wr), .line(t_line), .buf_valid(b_valid),
    .buf_line(b_line), .rd_busy(rd_valid), .dec(dec)
  );

  pwb_buf #(.LINE_W(LINE_W), .IDX_W(IDX_W), .BE_W(DW_BYTES)) u_buf (
    .clk(clk), .rst_n(arst_n), .post(dec.post), .force_fl(dec.force_fl),
    .in_line(t_line), .in_idx(t_idx), .in_be(pb_be), .in_burst(pb_burst),
    .flush_issue(flush_issue), .flush_done(flush_done),
    .valid(b_valid), .issued(b_issued), .hipri(b_hipri),
    .line(b_line), .idx(b_idx), .be(b_be), .burst(b_burst)
  );

  pwb_seq #(.LINE_W(LINE_W), .IDX_W(IDX_W), .BE_W(DW_BYTES), .BEATS(BEATS)) u_seq (
    .clk(clk), .rst_n(arst_n), .rd_take(dec.rd_take),
    .in_line(t_line), .in_idx(t_idx), .in_be(pb_be), .in_burst(pb_burst),
    .buf_valid(b_valid), .buf_issued(b_issued), .buf_hipri(b_hipri),
    .buf_line(b_line), .buf_idx(b_idx), .buf_be(b_be), .buf_burst(b_burst),
    .rd_valid(rd_valid), .flush_issue(flush_issue), .flush_done(flush_done),
    .req(mc_req), .req_rdy(mc_req_rdy), .req_wr(mc_req_wr), .req_hipri(mc_req_hipri),
    .req_burst(mc_req_burst), .req_addr(mc_req_addr), .req_be(mc_req_be),
    .req_order(mc_req_order), .data_go(mc_data_go), .data_done(mc_data_done)
  );

  always_comb begin
    aack_n_nx  = !(dec.rsp == RSP_ACK);
    artry_n_nx = !(dec.rsp == RSP_RETRY);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pb_aack_n  <= 1'b1;
      pb_artry_n <= 1'b1;
    end else begin
      pb_aack_n  <= aack_n_nx;
      pb_artry_n <= artry_n_nx;
    end
  end

  // R8
  one_answer_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pb_ts |=> (pb_aack_n != pb_artry_n));
  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !pb_ts |=> (pb_aack_n && pb_artry_n));
  // R5
  wr_busy_retry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (pb_ts && pb_wr && b_valid) |=> !pb_artry_n);
  // R1
  rd_empty_ack_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (pb_ts && !pb_wr && !b_valid && !rd_valid) |=> !pb_aack_n);
endmodule

// File: tb/tb_pwb_retry_ctrl.sv
module tb_pwb_retry_ctrl;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pb_ts = 0, pb_wr = 0, pb_burst = 0, mc_req_rdy = 0, mc_data_done = 0;
  logic [AW-1:0] pb_addr = '0;
  logic [7:0] pb_be = '0;
  logic pb_aack_n, pb_artry_n, mc_req, mc_req_wr, mc_req_hipri, mc_req_burst, mc_data_go;
  logic [AW-4:0] mc_req_addr;
  logic [7:0] mc_req_be, mc_req_order;

  pwb_retry_ctrl #(.ADDR_W(AW)) dut (.*);

  always #10 clk = ~clk;

  int vectors = 0, fails = 0, rdy_pct = 70, done_max = 3;
  bit finished = 0;
  int exp_rsp = 0;  // 0 none, 1 ack, 2 retry
  // model state
  bit bvalid, bissued, bforce, rvalid, m_pend, m_pend_fl, m_busy, m_cur_fl, prev_hold, lock_fl;
  int m_cnt;
  logic [AW-6:0] bline, rline;
  logic [1:0] bidx, ridx;
  logic [7:0] bbe, rbe, h_be, h_ord;
  logic bburst, rburst, h_wr, h_burst;
  logic [AW-4:0] h_addr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] f_order(input logic [1:0] i, input logic b);
    logic [7:0] o;
    for (int k = 0; k < 4; k++) o[2*k +: 2] = b ? 2'(i + 2'(k)) : i;
    return o;
  endfunction

  task automatic step(input bit ts, input bit wr, input bit bu, input logic [AW-1:0] a,
                      input logic [7:0] be);
    bit s_req, s_wr, s_hp, s_bu, s_go, rdy, done, exp_req, exp_go, fl, force_it;
    logic [AW-4:0] s_addr, e_addr;
    logic [7:0] s_be, s_ord, e_be;
    logic e_bu;
    @(negedge clk);
    // R8: answer pulse in the cycle after the tenure, both high otherwise
    chk("R8 aack_n", pb_aack_n, (exp_rsp == 1) ? 0 : 1);
    chk("R8 artry_n", pb_artry_n, (exp_rsp == 2) ? 0 : 1);
    s_req = mc_req; s_wr = mc_req_wr; s_hp = mc_req_hipri; s_bu = mc_req_burst;
    s_addr = mc_req_addr; s_be = mc_req_be; s_ord = mc_req_order; s_go = mc_data_go;
    rdy  = ($urandom % 100) < rdy_pct;
    done = m_busy && (m_cnt == 0);
    pb_ts = ts; pb_wr = wr; pb_burst = bu; pb_addr = a; pb_be = be;
    mc_req_rdy = rdy; mc_data_done = done;
    exp_req = !m_pend && ((bvalid && !bissued) || rvalid);
    exp_go  = m_pend && !m_busy;
    chk("R10 mc_req", s_req, exp_req);
    chk("R10 mc_data_go", s_go, exp_go);
    if (s_req && exp_req) begin
      fl = prev_hold ? lock_fl : (bvalid && !bissued);
      chk("R9 drain first", s_wr, fl);
      e_addr = fl ? {bline, bidx} : {rline, ridx};
      e_bu   = fl ? bburst : rburst;
      e_be   = e_bu ? 8'hFF : (fl ? bbe : rbe);
      chk(fl ? "R4 drain addr" : "R1 R2 read addr", s_addr, e_addr);
      chk(e_bu ? "R7 burst flag" : "R6 burst flag", s_bu, e_bu);
      chk(e_bu ? "R7 be" : "R6 be", s_be, e_be);
      chk("R7 order", s_ord, f_order(e_addr[1:0], e_bu));
      chk("R3 R5 hipri", s_hp, fl ? bforce : 1'b0);
      if (prev_hold) begin
        chk("R13 addr held", s_addr, h_addr);
        chk("R13 be held", s_be, h_be);
        chk("R13 order held", s_ord, h_ord);
        chk("R13 kind held", {s_wr, s_bu}, {h_wr, h_burst});
      end
      if (rdy) begin
        if (fl) begin bissued = 1; bforce = 0; end else rvalid = 0;
        m_pend = 1; m_pend_fl = fl; prev_hold = 0;
      end else begin
        prev_hold = 1; lock_fl = fl;
        h_addr = s_addr; h_be = s_be; h_ord = s_ord; h_wr = s_wr; h_burst = s_bu;
      end
    end else prev_hold = 0;
    if (exp_go && s_go) begin
      m_pend = 0; m_busy = 1; m_cur_fl = m_pend_fl; m_cnt = $urandom % (done_max + 1);
    end else if (done) begin
      m_busy = 0;
      if (m_cur_fl) begin bvalid = 0; bissued = 0; bforce = 0; end  // R11
    end else if (m_busy) m_cnt--;
    exp_rsp = 0; force_it = 0;
    if (ts) begin
      if (wr) begin
        if (bvalid || (done && m_cur_fl)) begin exp_rsp = 2; force_it = 1; end  // R5
        else begin  // R4
          exp_rsp = 1; bvalid = 1; bissued = 0; bforce = 0;
          bline = a[AW-1:5]; bidx = a[4:3]; bbe = be; bburst = bu;
        end
      end else if ((bvalid || (done && m_cur_fl)) && a[AW-1:5] == bline) begin
        exp_rsp = 2; force_it = 1;  // R3
      end else if (rvalid || (s_req && rdy && !fl && exp_req)) exp_rsp = 2;  // R12
      else begin  // R1 R2
        exp_rsp = 1; rvalid = 1;
        rline = a[AW-1:5]; ridx = a[4:3]; rbe = be; rburst = bu;
      end
    end
    if (force_it && bvalid && !bissued) bforce = 1;
  endtask

  task automatic rnd_step(input int ts_pct);
    logic [AW-1:0] a;
    a = '0;
    a[6:5] = 2'($urandom % 4);
    a[4:3] = 2'($urandom % 4);
    step(($urandom % 100) < ts_pct, $urandom % 2, $urandom % 2, a, 8'($urandom));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // reset state
    chk("R8 reset aack_n", pb_aack_n, 1);
    chk("R10 reset mc_req", mc_req, 0);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, '0, '0);
    // directed: post burst write at doubleword 2, then hit-read, miss-read, conflicting write
    rdy_pct = 0;
    step(1, 1, 1, 12'h050, 8'h00);  // R4 R7 order 2,3,0,1
    step(1, 0, 0, 12'h048, 8'h0F);  // R3 read hit -> retry
    step(1, 0, 0, 12'h028, 8'h3C);  // R2 miss -> ack
    step(1, 0, 0, 12'h060, 8'h01);  // R12 second read waits -> retry
    step(1, 1, 0, 12'h000, 8'h81);  // R5 write conflict -> retry
    repeat (3) step(0, 0, 0, '0, '0);  // R13 request held
    rdy_pct = 100;
    repeat (30) step(0, 0, 0, '0, '0);  // R9 R10 R11 drain then read
    step(1, 1, 0, 12'h018, 8'hA5);  // R4 R6 single write posted
    repeat (20) step(0, 0, 0, '0, '0);
    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      rdy_pct  = (ph % 2) ? 90 : 30;
      done_max = (ph < 2) ? 5 : 1;
      repeat (1500) rnd_step(ph == 3 ? 70 : 40);
    end
    rdy_pct = 100;
    repeat (40) step(0, 0, 0, '0, '0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule